// File: doc/BRIEF.md
# Mixed-Radix In-Place FFT Operand Address Generator

This block produces the data-memory read/write addresses for an in-place FFT whose size is N = R1^S1 × R2^S2. The transform runs in S = S1 + S2 passes. Passes 1 to S2 use radix-R2 butterflies, and the remaining S1 passes use radix-R1 butterflies. A single mixed-radix counter drives every pass. Its lowest digit steps fastest and names the operand inside the current butterfly. In each pass the counter digits are reordered and the reordered word is weighted into a binary address. No modulo arithmetic and no pass-specific address logic is needed. The butterfly's results go back to the same addresses it read.

The address leaves on a valid/ready stream. A beat stays on the outputs, unchanged, until a cycle where `addr_ready` is high, and no beat is dropped or repeated. When a pass has issued its last beat, the block stops and waits for `adv` before it starts the next pass. This gives the datapath time to drain its pipeline. A `start` pulse launches a transform only when the block is idle. Each beat is tagged with the pass number, the operand index, an end-of-pass flag and an end-of-transform flag.

Top module: `mr_fft_addr_gen`

## Requirements
- R1: After reset `addr_valid` is low, and it stays low while `start` is not asserted.
- R2: The operand index `addr_opidx` is the fastest counter digit. It counts 0..r'-1 repeatedly, where r' = R2 in passes 1..S2 and r' = R1 afterwards (for the 12-point case: 0,1 in passes 1 and 2, and 0,1,2 in pass 3).
- R3: In pass m, the address is the counter word with its lowest digit moved to sit just above digit S-m. Each digit is then weighted by the product of the radices below it. For the 12-point case (R1=3, R2=2, S1=1, S2=2), pass 1 yields 0,6,1,7,2,8,3,9,4,10,5,11.
- R4: For the 12-point case, pass 2 yields 0,3,1,4,2,5,6,9,7,10,8,11.
- R5: In the last pass the address equals the counter value, so the 12-point case yields 0..11 in order.
- R6: `addr_stage` carries the pass number, 1..S, of every beat.
- R7: `addr_pass_end` is high on exactly the last beat of each pass. `addr_xform_end` is high only on the last beat of pass S.
- R8: After a non-final pass ends, no beat is issued until `adv` is pulsed. An `adv` pulse while a pass is running has no effect.
- R9: `start` while a transform is running or waiting between passes has no effect.
- R10: While `addr_valid` is high and `addr_ready` is low, all beat outputs hold steady. Every address is delivered exactly once.
- R11: After the final beat is accepted the block is idle (`addr_valid` low), and a new `start` runs the whole sequence again from pass 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform (honoured only while idle) |
| adv | input | 1 | Permit the next pass (honoured only between passes) |
| addr_valid | output | 1 | Beat present |
| addr_ready | input | 1 | Consumer accepts the beat |
| addr | output | AW | Data-memory address |
| addr_stage | output | SW | Pass number 1..S |
| addr_opidx | output | DW | Operand index within the butterfly |
| addr_pass_end | output | 1 | Last beat of the current pass |
| addr_xform_end | output | 1 | Last beat of the whole transform |

## Verification
The bench compares all 36 beats of the 12-point transform, including the operand indices and flags, against the known sequences for each pass. If the digit placement were wrong, pass 1 or pass 2 would come out in a different order. If the radix pattern were not reloaded at the pass boundary, pass 3 would count its operand index in twos. The same run is repeated with `addr_ready` dropping on a regular pattern; an output register that advanced while stalled would lose or duplicate addresses and change the beat count. Stray `start` and `adv` pulses are injected in the middle of a pass, and the bench watches the wait between passes. A design that honoured them would skip a pass, restart, or issue beats before being released.

// File: rtl/mr_addr_pkg.sv
`timescale 1ns/1ps
package mr_addr_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} seq_st_t;

  function automatic int ipow(input int base, input int expo);
    int r;
    r = 1;
    for (int i = 0; i < expo; i++) r = r * base;
    return r;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Radix of counter digit i during pass m (1-based).
  function automatic int digit_radix(input int i, input int m, input int s1,
                                     input int s2, input int r1, input int r2);
    if (m <= s2) begin
      if (i >= 1 && i <= s1) return r1;
      return r2;
    end
    if (i < s1) return r1;
    return r2;
  endfunction

endpackage

// File: rtl/mr_digit_ctr.sv
`timescale 1ns/1ps
module mr_digit_ctr #(
  parameter int S  = 3,
  parameter int DW = 2,
  parameter int RW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  inc,
  input  logic [S-1:0][RW-1:0]  radix,
  output logic [S-1:0][DW-1:0]  dig,
  output logic                  full
);
  logic [S-1:0] at_max;
  logic [S-1:0] carry;

  for (genvar g = 0; g < S; g++) begin : g_digit
    assign at_max[g] = (RW'(dig[g]) == (radix[g] - RW'(1)));

    if (g == 0) begin : g_lsd
      assign carry[g] = inc;
    end else begin : g_upper
      assign carry[g] = carry[g-1] & at_max[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dig[g] <= '0;
      else if (clr)       dig[g] <= '0;
      else if (carry[g])  dig[g] <= at_max[g] ? '0 : dig[g] + DW'(1);
    end
  end

  assign full = &at_max;
endmodule

// File: rtl/mr_addr_map.sv
`timescale 1ns/1ps
module mr_addr_map #(
  parameter int S  = 3,
  parameter int DW = 2,
  parameter int RW = 2,
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic [S-1:0][DW-1:0] dig,
  input  logic [S-1:0][RW-1:0] radix,
  input  logic [SW-1:0]        stage,
  output logic [AW-1:0]        addr
);
  // Address positions, low to high: C1..C(S-m), C0, C(S-m+1)..C(S-1).
  always_comb begin
    int          k;
    int          idx;
    logic [31:0] w;
    logic [31:0] sum;
    k   = (stage == '0) ? (S - 1) : (S - int'(stage));
    w   = 32'd1;
    sum = 32'd0;
    for (int p = 0; p < S; p++) begin
      if (p < k)       idx = p + 1;
      else if (p == k) idx = 0;
      else             idx = p;
      sum = sum + 32'(dig[idx]) * w;
      w   = w * 32'(radix[idx]);
    end
    addr = AW'(sum);
  end
endmodule

// File: rtl/mr_seq_ctrl.sv
`timescale 1ns/1ps
module mr_seq_ctrl
  import mr_addr_pkg::*;
#(
  parameter int S  = 3,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic          can_issue,
  input  logic          full,
  output logic          issue,
  output logic          clr,
  output logic [SW-1:0] stage,
  output logic          final_pass
);
  seq_st_t st;

  assign issue      = (st == ST_RUN) && can_issue;
  assign clr        = ((st == ST_IDLE) && start) || ((st == ST_HOLD) && adv);
  assign final_pass = (stage == SW'(S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      stage <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st    <= ST_RUN;
          stage <= SW'(1);
        end
        ST_RUN: if (issue && full) begin
          if (final_pass) begin
            st    <= ST_IDLE;
            stage <= '0;
          end else begin
            st <= ST_HOLD;
          end
        end
        ST_HOLD: if (adv) begin
          st    <= ST_RUN;
          stage <= stage + SW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mr_fft_addr_gen.sv
`timescale 1ns/1ps
module mr_fft_addr_gen
  import mr_addr_pkg::*;
#(
  parameter int R1 = 3,
  parameter int R2 = 2,
  parameter int S1 = 1,
  parameter int S2 = 2,
  localparam int S    = S1 + S2,
  localparam int N    = ipow(R1, S1) * ipow(R2, S2),
  localparam int RMAX = imax(R1, R2),
  localparam int DW   = (RMAX > 2) ? $clog2(RMAX) : 1,
  localparam int RW   = $clog2(RMAX + 1),
  localparam int AW   = (N > 2) ? $clog2(N) : 1,
  localparam int SW   = $clog2(S + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic [SW-1:0] addr_stage,
  output logic [DW-1:0] addr_opidx,
  output logic          addr_pass_end,
  output logic          addr_xform_end
);
  logic                 can_issue, issue, clr, full, final_pass;
  logic [SW-1:0]        stage;
  logic [S-1:0][RW-1:0] radix;
  logic [S-1:0][DW-1:0] dig;
  logic [AW-1:0]        next_addr;

  assign can_issue = !addr_valid || addr_ready;

  for (genvar g = 0; g < S; g++) begin : g_rad
    assign radix[g] = RW'(digit_radix(g, int'(stage), S1, S2, R1, R2));
  end

  mr_seq_ctrl #(.S(S), .SW(SW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .can_issue(can_issue), .full(full), .issue(issue), .clr(clr),
    .stage(stage), .final_pass(final_pass)
  );

  mr_digit_ctr #(.S(S), .DW(DW), .RW(RW)) i_ctr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(issue),
    .radix(radix), .dig(dig), .full(full)
  );

  mr_addr_map #(.S(S), .DW(DW), .RW(RW), .AW(AW), .SW(SW)) i_map (
    .dig(dig), .radix(radix), .stage(stage), .addr(next_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid     <= 1'b0;
      addr           <= '0;
      addr_stage     <= '0;
      addr_opidx     <= '0;
      addr_pass_end  <= 1'b0;
      addr_xform_end <= 1'b0;
    end else if (issue) begin
      addr_valid     <= 1'b1;
      addr           <= next_addr;
      addr_stage     <= stage;
      addr_opidx     <= dig[0];
      addr_pass_end  <= full;
      addr_xform_end <= full && final_pass;
    end else if (addr_ready) begin
      addr_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/mr_fft_addr_gen_chk.sv
`timescale 1ns/1ps
module mr_fft_addr_gen_chk #(
  parameter int N  = 12,
  parameter int S  = 3,
  parameter int S2 = 2,
  parameter int R1 = 3,
  parameter int R2 = 2,
  parameter int AW = 4,
  parameter int SW = 2,
  parameter int DW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic [SW-1:0] addr_stage,
  input logic [DW-1:0] addr_opidx,
  input logic          addr_pass_end,
  input logic          addr_xform_end
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr) &&
      $stable(addr_stage) && $stable(addr_opidx) && $stable(addr_pass_end));

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> int'(addr) < N);

  assert_opidx_radix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> int'(addr_opidx) < ((int'(addr_stage) <= S2) ? R2 : R1));

  assert_stage_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> addr_stage != '0 && int'(addr_stage) <= S);

  assert_xform_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_xform_end |-> addr_pass_end && int'(addr_stage) == S);

  assert_pass_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && addr_pass_end |=> !addr_valid);
endmodule

bind mr_fft_addr_gen mr_fft_addr_gen_chk #(
  .N(N), .S(S), .S2(S2), .R1(R1), .R2(R2), .AW(AW), .SW(SW), .DW(DW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr(addr), .addr_stage(addr_stage), .addr_opidx(addr_opidx),
  .addr_pass_end(addr_pass_end), .addr_xform_end(addr_xform_end)
);

// File: tb/test_mr_fft_addr_gen.sv
`timescale 1ns/1ps
module test_mr_fft_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       adv = 1'b0;
  logic       addr_ready = 1'b1;
  logic       addr_valid;
  logic [3:0] addr;
  logic [1:0] addr_stage;
  logic [1:0] addr_opidx;
  logic       addr_pass_end, addr_xform_end;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int got_addr [0:63];
  int got_stage[0:63];
  int got_op   [0:63];
  bit got_pe   [0:63];
  bit got_xe   [0:63];
  int nb = 0;
  bit cap_en = 1'b0;
  bit need_adv = 1'b0;
  bit done_flag = 1'b0;

  int exp1[0:11] = '{0,6,1,7,2,8,3,9,4,10,5,11};
  int exp2[0:11] = '{0,3,1,4,2,5,6,9,7,10,8,11};

  always #2 clk = ~clk;

  mr_fft_addr_gen i_mr_fft_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .addr_stage(addr_stage), .addr_opidx(addr_opidx),
    .addr_pass_end(addr_pass_end), .addr_xform_end(addr_xform_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_up();
    end
  end

  // Beat monitor: a beat seen valid and ready here transfers at the next edge.
  always @(negedge clk) begin
    if (cap_en && rst_n && addr_valid && addr_ready && nb < 64) begin
      got_addr[nb]  = int'(addr);
      got_stage[nb] = int'(addr_stage);
      got_op[nb]    = int'(addr_opidx);
      got_pe[nb]    = addr_pass_end;
      got_xe[nb]    = addr_xform_end;
      nb++;
      if (addr_xform_end) done_flag = 1'b1;
      else if (addr_pass_end) need_adv = 1'b1;
    end
  end

  // One full transform; mode 1 throttles ready, poke injects stray start/adv.
  task automatic drive_run(input bit throttle, input int gap, input bit poke);
    nb = 0; done_flag = 1'b0; need_adv = 1'b0; cap_en = 1'b1;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int cyc = 0; cyc < 3000 && !done_flag; cyc++) begin
      @(posedge clk); #1;
      addr_ready = throttle ? (cyc % 3 != 1) : 1'b1;
      start = poke && (cyc == 5 || cyc == 9);  // R9: stray start mid-pass
      adv   = poke && (cyc == 4);              // R8: stray adv mid-pass
      if (need_adv) begin
        need_adv = 1'b0; start = 1'b0; adv = 1'b0;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk(addr_valid == 1'b0, "R8 no beat before adv", int'(addr_valid), 0);
        end
        @(posedge clk); #1 adv = 1'b1;
        @(posedge clk); #1 adv = 1'b0;
      end
    end
    @(posedge clk); #1;
    start = 1'b0; adv = 1'b0; addr_ready = 1'b1;
    for (int g = 0; g < 10; g++) begin
      @(negedge clk);
      chk(addr_valid == 1'b0, "R11 idle after transform", int'(addr_valid), 0);
    end
    cap_en = 1'b0;
  endtask

  task automatic verify_beats(input string tag);
    chk(nb == 36, "R10 beat count", nb, 36);
    for (int i = 0; i < 36 && i < nb; i++) begin
      int ps, j, ea, eo;
      ps = i / 12 + 1;
      j  = i % 12;
      ea = (ps == 1) ? exp1[j] : (ps == 2) ? exp2[j] : j;
      eo = (ps == 3) ? (j % 3) : (j % 2);
      if (ps == 1)      chk(got_addr[i] == ea, "R3 pass1 address", got_addr[i], ea);
      else if (ps == 2) chk(got_addr[i] == ea, "R4 pass2 address", got_addr[i], ea);
      else              chk(got_addr[i] == ea, "R5 last pass address", got_addr[i], ea);
      chk(got_op[i] == eo, "R2 operand index", got_op[i], eo);
      chk(got_stage[i] == ps, "R6 pass number", got_stage[i], ps);
      chk(got_pe[i] == (j == 11), "R7 pass end flag", int'(got_pe[i]), int'(j == 11));
      chk(got_xe[i] == (i == 35), "R7 transform end flag", int'(got_xe[i]), int'(i == 35));
    end
    if (errors != 0) $display("after %s: %0d errors so far", tag, errors);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(addr_valid == 1'b0, "R1 valid low in reset", int'(addr_valid), 0);
    #1 rst_n = 1'b1;
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      chk(addr_valid == 1'b0, "R1 idle without start", int'(addr_valid), 0);
    end
  endtask

  task automatic t_plain();
    drive_run(1'b0, 3, 1'b0);
    verify_beats("plain");
  endtask

  task automatic t_backpressure();
    drive_run(1'b1, 2, 1'b0);
    verify_beats("R10 backpressure");
  endtask

  task automatic t_stray_controls();
    drive_run(1'b0, 6, 1'b1);
    verify_beats("R8 R9 stray controls");
  endtask

  task automatic t_restart();
    drive_run(1'b0, 1, 1'b0);
    verify_beats("R11 restart");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_backpressure();
    t_stray_controls();
    t_restart();
    finish_up();
  end
endmodule